// File: doc/BRIEF.md
# Dual-Channel Programmable Interval and One-Shot Timer

This block holds two timer channels built around 16-bit count and modulus registers and drives three interrupt request lines. Channel 0 is steered by the mode bit of its control byte. In one-shot mode it arms up to two independent single-shot delays: one is timed from the count register and the other from the modulus register. In interval mode it produces a periodic request timed from its modulus register. Channel 1 only produces periodic requests.

Each delay lasts prescale × register value × multiplier clock cycles. The prescale value comes from the clock control logic and is sampled when the control byte is written. The multiplier is picked by a control bit: either ×128, or ×12 for one-shots and ×6 for intervals. A register value of zero counts as 2^CNT_W units.

A processor reaches the block through a simple register port. Writes take effect on a clock edge and reads are combinational. Each request output is a level flag that stays set until it is acknowledged.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads zero, no delay is armed and all three request outputs are low.
- R2: Address 0 (channel 0 count), 1 (channel 0 modulus), 2 (channel 1 count) and 3 (channel 1 modulus) are CNT_W-bit registers. A write lands on the clock edge, and a read returns the stored value combinationally.
- R3: Address 4 (channel 0 control) keeps all 8 written bits. Address 5 (channel 1 control) keeps only bits 7:6 and reads zero in every other bit.
- R4: A control-0 write with bit 0 = 1 (one-shot) and bit 7 = 1 raises request 0 once, P × count0 × (bit 6 ? 128 : 12) cycles after the write edge. It does not raise it again.
- R5: A control-0 write with bit 0 = 1 and bit 5 = 1 raises request 1 once, P × modulus0 × (bit 4 ? 128 : 12) cycles after the write edge. A later control-0 write with bit 5 = 0 cancels a pending one.
- R6: A control-0 write with bit 0 = 0 (interval) and bit 7 = 1 raises request 0 every P × modulus0 × (bit 6 ? 128 : 6) cycles. It also copies modulus0 into count0 and cancels the request-1 delay.
- R7: A control-0 write with bit 0 = 0 and bit 7 = 0 stops both channel-0 delays.
- R8: A control-1 write with bit 7 = 1 raises request 2 every P × modulus1 × (bit 6 ? 128 : 6) cycles and copies modulus1 into count1. A write with bit 7 = 0 stops it.
- R9: A register value of zero gives a delay of 2^CNT_W units.
- R10: A request stays high until its acknowledge bit is seen on a clock edge, and it is low after that edge. If a delay expires in the same cycle as an acknowledge, the request stays set.
- R11: Each control write restarts the delays it arms from a zero count. P is the prescale input sampled at that write (zero counts as one), and later changes to the input do not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data; control bytes use bits 7:0 |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| prescale | input | PRE_W | Prescale factor from clock control, sampled at control writes |
| irq_ack | input | 3 | Per-request acknowledge |
| irq_req | output | 3 | Level interrupt requests 0, 1, 2 |

## Verification
Take the edge that samples a control write as edge E. A delay of D cycles sets its request on edge E+D. The bench counts clock edges and, for each request, samples it just after edge E+D−1, expecting it low, and just after edge E+D, expecting it high. A periodic request is checked the same way at E+2D, after an acknowledge that clears it one edge after the acknowledge is applied. Register reads are combinational, so they are sampled one time unit after the address changes, in the low half of the clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CNT0 = 3'd0,
    A_MOD0 = 3'd1,
    A_CNT1 = 3'd2,
    A_MOD1 = 3'd3,
    A_CTL0 = 3'd4,
    A_CTL1 = 3'd5
  } tmr_addr_e;

  localparam int NUM_EV   = 3;
  localparam int MUL_SHOT = 12;
  localparam int MUL_PER  = 6;
  localparam int MUL_BIG  = 128;
  localparam int MUL_W    = 8;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int SPAN_W = PRE_W + CNT_W + 1 + MUL_W
) (
  input  logic                           ctl0_wr,
  input  logic                           ctl1_wr,
  input  logic [7:0]                     cbyte,
  input  logic [PRE_W-1:0]               prescale,
  input  logic [CNT_W-1:0]               cnt0,
  input  logic [CNT_W-1:0]               mod0,
  input  logic [CNT_W-1:0]               mod1,
  output logic [NUM_EV-1:0]              ev_start,
  output logic [NUM_EV-1:0]              ev_stop,
  output logic [NUM_EV-1:0]              ev_periodic,
  output logic [NUM_EV-1:0][SPAN_W-1:0]  ev_span_m1
);
  // multiplier picked by the "long" bit and by the kind of delay
  function automatic int pick_mul(input logic long_sel, input logic single);
    if (long_sel) return MUL_BIG;
    return single ? MUL_SHOT : MUL_PER;
  endfunction

  // delay in cycles minus one; zero register value means 2^CNT_W units
  function automatic logic [SPAN_W-1:0] span_less_one(
    input logic [PRE_W-1:0] pre, input logic [CNT_W-1:0] units, input int mul);
    logic [SPAN_W-1:0] u, p, m;
    u = (units == '0) ? (SPAN_W'(1) << CNT_W) : SPAN_W'(units);
    p = (pre == '0) ? SPAN_W'(1) : SPAN_W'(pre);
    m = SPAN_W'(mul);
    return (p * u * m) - SPAN_W'(1);
  endfunction

  logic single_mode;
  assign single_mode = cbyte[0];

  always_comb begin
    // event 0: channel 0 main delay (one-shot or interval)
    ev_start[0]    = ctl0_wr && cbyte[7];
    ev_stop[0]     = ctl0_wr && !cbyte[7];
    ev_periodic[0] = !single_mode;
    ev_span_m1[0]  = single_mode
                   ? span_less_one(prescale, cnt0, pick_mul(cbyte[6], 1'b1))
                   : span_less_one(prescale, mod0, pick_mul(cbyte[6], 1'b0));
    // event 1: channel 0 second one-shot, only alive in one-shot mode
    ev_start[1]    = ctl0_wr && single_mode && cbyte[5];
    ev_stop[1]     = ctl0_wr && !(single_mode && cbyte[5]);
    ev_periodic[1] = 1'b0;
    ev_span_m1[1]  = span_less_one(prescale, mod0, pick_mul(cbyte[4], 1'b1));
    // event 2: channel 1 interval
    ev_start[2]    = ctl1_wr && cbyte[7];
    ev_stop[2]     = ctl1_wr && !cbyte[7];
    ev_periodic[2] = 1'b1;
    ev_span_m1[2]  = span_less_one(prescale, mod1, pick_mul(cbyte[6], 1'b0));
  end
endmodule

// File: rtl/tmr_event.sv
module tmr_event #(
  parameter int SPAN_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              periodic,
  input  logic [SPAN_W-1:0] span_m1,
  output logic              fire,
  output logic              busy
);
  logic [SPAN_W-1:0] cnt_q, rel_q;
  logic              per_q, busy_q;

  assign fire = busy_q && (cnt_q == '0) && !start && !stop;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      per_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      per_q  <= periodic;
      cnt_q  <= span_m1;
      rel_q  <= span_m1;
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (per_q) cnt_q  <= rel_q;
        else       busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_ONESHOT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per_q) |=> !busy) else $error("one-shot stayed armed"); // R4
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !fire)) else $error("start did not arm from full count"); // R11
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy) else $error("stop left delay armed"); // R7
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  input  logic [N-1:0] ack,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (fire[i]) flag_q <= 1'b1;
      else if (ack[i])  flag_q <= 1'b0;
    end
    assign req[i] = flag_q;

    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> req[i]) else $error("expiry lost"); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !fire[i]) |=> !req[i]) else $error("ack ignored"); // R10
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && !ack[i]) |=> req[i]) else $error("request dropped"); // R10
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [NUM_EV-1:0]  irq_ack,
  output logic [NUM_EV-1:0]  irq_req
);
  localparam int SPAN_W = PRE_W + CNT_W + 1 + MUL_W;

  logic [CNT_W-1:0] cnt0_q, mod0_q, cnt1_q, mod1_q;
  logic [7:0]       ctl0_q;
  logic [1:0]       ctl1_q;

  logic ctl0_wr, ctl1_wr;
  logic [7:0] cbyte;
  logic iv0_start, iv1_start;

  logic [NUM_EV-1:0]             ev_start, ev_stop, ev_periodic, ev_fire, ev_busy;
  logic [NUM_EV-1:0][SPAN_W-1:0] ev_span_m1;

  assign cbyte     = reg_wdata[7:0];
  assign ctl0_wr   = reg_we && (reg_addr == A_CTL0);
  assign ctl1_wr   = reg_we && (reg_addr == A_CTL1);
  assign iv0_start = ctl0_wr && !cbyte[0] && cbyte[7];
  assign iv1_start = ctl1_wr && cbyte[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0_q <= '0;
      mod0_q <= '0;
      cnt1_q <= '0;
      mod1_q <= '0;
      ctl0_q <= '0;
      ctl1_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_CNT0) cnt0_q <= reg_wdata;
      else if (iv0_start)                cnt0_q <= mod0_q;
      if (reg_we && reg_addr == A_MOD0) mod0_q <= reg_wdata;
      if (reg_we && reg_addr == A_CNT1) cnt1_q <= reg_wdata;
      else if (iv1_start)                cnt1_q <= mod1_q;
      if (reg_we && reg_addr == A_MOD1) mod1_q <= reg_wdata;
      if (ctl0_wr) ctl0_q <= cbyte;
      if (ctl1_wr) ctl1_q <= cbyte[7:6];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CNT0:  reg_rdata = cnt0_q;
      A_MOD0:  reg_rdata = mod0_q;
      A_CNT1:  reg_rdata = cnt1_q;
      A_MOD1:  reg_rdata = mod1_q;
      A_CTL0:  reg_rdata = CNT_W'(ctl0_q);
      A_CTL1:  reg_rdata = CNT_W'({ctl1_q, 6'b0});
      default: reg_rdata = '0;
    endcase
  end

  tmr_decode #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SPAN_W(SPAN_W)) u_decode (
    .ctl0_wr     (ctl0_wr),
    .ctl1_wr     (ctl1_wr),
    .cbyte       (cbyte),
    .prescale    (prescale),
    .cnt0        (cnt0_q),
    .mod0        (mod0_q),
    .mod1        (mod1_q),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .ev_periodic (ev_periodic),
    .ev_span_m1  (ev_span_m1)
  );

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    tmr_event #(.SPAN_W(SPAN_W)) u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (ev_start[e]),
      .stop     (ev_stop[e]),
      .periodic (ev_periodic[e]),
      .span_m1  (ev_span_m1[e]),
      .fire     (ev_fire[e]),
      .busy     (ev_busy[e])
    );
  end

  tmr_irq_flags #(.N(NUM_EV)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (ev_fire),
    .ack   (irq_ack),
    .req   (irq_req)
  );

  AST_TM0_FROM_MD0: assert property (@(posedge clk) disable iff (!rst_n)
    iv0_start |=> (cnt0_q == $past(mod0_q))) else $error("count0 not loaded"); // R6
  AST_TM1_FROM_MD1: assert property (@(posedge clk) disable iff (!rst_n)
    iv1_start |=> (cnt1_q == $past(mod1_q))) else $error("count1 not loaded"); // R8
  AST_IV_DROPS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_wr && !cbyte[0]) |=> !ev_busy[1]) else $error("second shot survived"); // R6
  AST_HALT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_wr && !cbyte[0] && !cbyte[7]) |=> (ev_busy[1:0] == 2'b00)) else $error("halt failed"); // R7
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [PW-1:0] prescale = 4'd1;
  logic [2:0]    irq_ack = '0;
  logic [2:0]    irq_req;

  int cyc = 0;
  int e_wr = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_pair #(.CNT_W(CW), .PRE_W(PW)) u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prescale(prescale),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    e_wr = cyc;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == CW'(exp), tag, reg_rdata, exp);
  endtask

  task automatic ack(input logic [2:0] m);
    @(negedge clk);
    irq_ack = m;
    @(negedge clk);
    irq_ack = '0;
  endtask

  task automatic expect_rise(input int idx, input int t, input string tag);
    while (cyc < t - 1) @(negedge clk);
    chk(irq_req[idx] == 1'b0, {tag, " early"}, irq_req[idx], 0);
    @(negedge clk);
    chk(irq_req[idx] == 1'b1, {tag, " due"}, irq_req[idx], 1);
  endtask

  task automatic quiet(input int n, input logic [2:0] m, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((irq_req & m) != 0) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic cleanup();
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
    ack(3'b111);
  endtask

  task automatic t_reset();
    rd(3'd0, 0, "R1 count0");
    rd(3'd1, 0, "R1 mod0");
    rd(3'd4, 0, "R1 ctl0");
    rd(3'd5, 0, "R1 ctl1");
    chk(irq_req == 3'b000, "R1 requests", irq_req, 0);
    quiet(50, 3'b111, "R1 nothing armed");
  endtask

  task automatic t_regs();
    wr(3'd0, 8'h5A); wr(3'd1, 8'h33); wr(3'd2, 8'h12); wr(3'd3, 8'hFF);
    rd(3'd0, 8'h5A, "R2 count0");
    rd(3'd1, 8'h33, "R2 mod0");
    rd(3'd2, 8'h12, "R2 count1");
    rd(3'd3, 8'hFF, "R2 mod1");
    wr(3'd4, 8'h7E);
    rd(3'd4, 8'h7E, "R3 ctl0 all bits");
    wr(3'd5, 8'h7F);
    rd(3'd5, 8'h40, "R3 ctl1 masked");
    cleanup();
  endtask

  task automatic t_oneshot_a();
    prescale = 4'd2;
    wr(3'd0, 8'd3);
    wr(3'd4, 8'h81);                       // 2*3*12 = 72
    expect_rise(0, e_wr + 72, "R4 short mult");
    ack(3'b001);
    chk(irq_req[0] == 1'b0, "R10 ack clears", irq_req[0], 0);
    quiet(100, 3'b011, "R4 no repeat");
    prescale = 4'd1;
    wr(3'd0, 8'd1);
    wr(3'd4, 8'hC1);                       // 1*1*128
    expect_rise(0, e_wr + 128, "R4 long mult");
    cleanup();
  endtask

  task automatic t_oneshot_b();
    prescale = 4'd1;
    wr(3'd1, 8'd2);
    wr(3'd4, 8'h21);                       // 1*2*12 = 24
    expect_rise(1, e_wr + 24, "R5 short mult");
    chk(irq_req[0] == 1'b0, "R5 request0 idle", irq_req[0], 0);
    ack(3'b010);
    wr(3'd1, 8'd1);
    wr(3'd4, 8'h31);                       // 128
    expect_rise(1, e_wr + 128, "R5 long mult");
    ack(3'b010);
    wr(3'd1, 8'd2);
    wr(3'd4, 8'h21);
    quiet(10, 3'b010, "R5 pending");
    wr(3'd4, 8'h01);
    quiet(40, 3'b011, "R5 cancel");
    cleanup();
  endtask

  task automatic t_interval0();
    int e0;
    prescale = 4'd1;
    wr(3'd1, 8'd4);
    wr(3'd0, 8'd9);
    wr(3'd4, 8'h21);                       // second one-shot, 48 cycles
    quiet(5, 3'b010, "R6 prior shot");
    wr(3'd4, 8'h80);                       // interval, 24 cycles
    e0 = e_wr;
    rd(3'd0, 4, "R6 count0 loaded");
    expect_rise(0, e0 + 24, "R6 first period");
    ack(3'b001);
    chk(irq_req[0] == 1'b0, "R10 cleared between", irq_req[0], 0);
    expect_rise(0, e0 + 48, "R6 second period");
    quiet(30, 3'b010, "R6 shot cancelled");
    cleanup();
    wr(3'd1, 8'd1);
    wr(3'd4, 8'hC0);                       // 128
    expect_rise(0, e_wr + 128, "R6 long mult");
    cleanup();
  endtask

  task automatic t_halt();
    prescale = 4'd1;
    wr(3'd0, 8'd2); wr(3'd1, 8'd2);
    wr(3'd4, 8'hA1);                       // both one-shots, 24 cycles
    quiet(5, 3'b011, "R7 armed");
    wr(3'd4, 8'h00);
    quiet(60, 3'b011, "R7 halted both");
    wr(3'd1, 8'd1);
    wr(3'd4, 8'h80);                       // 6-cycle interval
    expect_rise(0, e_wr + 6, "R7 interval live");
    wr(3'd4, 8'h00);
    ack(3'b001);
    quiet(40, 3'b001, "R7 interval halted");
    cleanup();
  endtask

  task automatic t_timer1();
    int e0;
    prescale = 4'd3;
    wr(3'd3, 8'd2);
    wr(3'd5, 8'h80);                       // 3*2*6 = 36
    e0 = e_wr;
    rd(3'd2, 2, "R8 count1 loaded");
    expect_rise(2, e0 + 36, "R8 first period");
    ack(3'b100);
    expect_rise(2, e0 + 72, "R8 second period");
    wr(3'd5, 8'h00);
    ack(3'b100);
    quiet(80, 3'b100, "R8 stopped");
    prescale = 4'd1;
    wr(3'd3, 8'd1);
    wr(3'd5, 8'hC0);                       // 128
    expect_rise(2, e_wr + 128, "R8 long mult");
    cleanup();
  endtask

  task automatic t_zero();
    prescale = 4'd1;
    wr(3'd3, 8'd0);
    wr(3'd5, 8'h80);                       // 256*6 = 1536
    expect_rise(2, e_wr + 1536, "R9 zero means full range");
    cleanup();
  endtask

  task automatic t_collide();
    int e0;
    prescale = 4'd1;
    wr(3'd1, 8'd1);
    wr(3'd4, 8'h80);                       // period 6
    e0 = e_wr;
    irq_ack = 3'b001;
    while (cyc < e0 + 6) @(negedge clk);
    chk(irq_req[0] == 1'b1, "R10 expiry beats ack", irq_req[0], 1);
    @(negedge clk);
    chk(irq_req[0] == 1'b0, "R10 ack next edge", irq_req[0], 0);
    while (cyc < e0 + 12) @(negedge clk);
    chk(irq_req[0] == 1'b1, "R10 second expiry", irq_req[0], 1);
    irq_ack = '0;
    cleanup();
  endtask

  task automatic t_restart();
    prescale = 4'd2;
    wr(3'd0, 8'd3);
    wr(3'd4, 8'h81);                       // 72 cycles
    quiet(30, 3'b001, "R11 first run");
    prescale = 4'd1;
    wr(3'd4, 8'h81);                       // restart: 36 cycles
    prescale = 4'd4;                       // must not matter now
    expect_rise(0, e_wr + 36, "R11 restart and sampled prescale");
    ack(3'b001);
    quiet(60, 3'b001, "R11 old run gone");
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_oneshot_a();
    t_oneshot_b();
    t_interval0();
    t_halt();
    t_timer1();
    t_zero();
    t_collide();
    t_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule